// File: doc/BRIEF.md
# Monitor Mode Entry and Vector Remapper

This block chooses, each time the external reset pin is released, whether the device comes up in monitor (debug) mode or in normal user mode. At the release edge it looks at a small group of strap pins together with a high-voltage detector on the interrupt pin. Monitor mode is selected only when the detector reports high voltage and the straps carry the expected code. A software-interrupt indication from the CPU also switches the device into monitor mode. Once set, the mode stays until the reset pin is asserted again.

While in monitor mode the block redirects the CPU's vector fetches to a separate vector page, so the reset vector and the software-interrupt/break vector are read from the monitor region instead of the user vector table. Only cycles flagged as vector fetches are redirected. Plain data reads go through unchanged. The block also decodes the chip select for the monitor program region, turns the watchdog off in monitor mode, and selects the crystal-divided-by-two bus clock source.

Top module: `mon_entry_remap`

## Requirements
- R1: While the synchronous reset `rst` is high, or while `rst_pin_n` is low, the mode is user: `mon_mode`=0, `wdog_disable`=0, `clk_sel_xtal`=0.
- R2: On the clock edge that first sees `rst_pin_n` high after it was low, `mon_mode` becomes 1 only if `irq_hv`=1 and `strap_pins`=3'b101 (bit 2 = 1, bit 1 = 0, bit 0 = 1). Otherwise `mon_mode` becomes 0.
- R3: After release, `mon_mode` does not change while `rst_pin_n` stays high and `swi_exec` is low, whatever `strap_pins` and `irq_hv` do.
- R4: A cycle with `swi_exec`=1 and `rst_pin_n`=1 makes `mon_mode`=1 from the next cycle on.
- R5: In monitor mode, a vector fetch of 0xFFFE or 0xFFFF drives `mapped_addr` to 0xFEFE or 0xFEFF respectively (same cycle).
- R6: In monitor mode, a vector fetch of 0xFFFC or 0xFFFD drives `mapped_addr` to 0xFEFC or 0xFEFD.
- R7: `mapped_addr` equals `cpu_addr` when `vec_fetch`=0, when in user mode, or for vector addresses below 0xFFFC (e.g. 0xFFFA).
- R8: `mon_rom_sel`=1 exactly when `mon_mode`=1 and `mapped_addr` lies in 0xFE10..0xFEFF inclusive.
- R9: `wdog_disable` and `clk_sel_xtal` (1 = crystal clock divided by two) are both 1 in monitor mode and 0 in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | External reset pin level, low = asserted |
| irq_hv | input | 1 | High-voltage detect on the interrupt pin |
| strap_pins | input | 3 | Mode strap pin levels |
| swi_exec | input | 1 | CPU is executing a software interrupt |
| cpu_addr | input | 16 | CPU address bus |
| vec_fetch | input | 1 | Current bus cycle is a vector fetch |
| mon_mode | output | 1 | 1 = monitor mode, 0 = user mode |
| mapped_addr | output | 16 | Address after vector remapping |
| mon_rom_sel | output | 1 | Chip select for the monitor program region |
| wdog_disable | output | 1 | 1 = watchdog disabled |
| clk_sel_xtal | output | 1 | 1 = bus clock from crystal divided by two |

## Verification
The embedded properties check on every cycle that reset-pin assertion forces user mode, that the mode holds while no reset edge or software interrupt occurs, that a software interrupt always lands in monitor mode, that addresses pass through untouched outside monitor vector fetches, and that the ROM select never appears in user mode. Which strap and detector combination actually selects monitor mode, the exact redirected addresses, and the edges of the ROM window (0xFE0F versus 0xFE10) can only be shown by the directed scenarios. The bench drives known pin patterns and bus addresses for these.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int ADDR_W = 16;
    localparam int PAGE_W = ADDR_W / 2;

    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_MON  = 1'b1
    } mode_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] offset;
    } bus_addr_t;

    function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic in_vec_window(input bus_addr_t a,
                                           input logic [PAGE_W-1:0] page,
                                           input logic [PAGE_W-1:0] low_offset);
        return (a.page == page) && (a.offset >= low_offset);
    endfunction

endpackage

// File: rtl/mon_mode_latch.sv
module mon_mode_latch
    import mon_pkg::*;
#(
    parameter int               STRAP_W   = 3,
    parameter logic [STRAP_W-1:0] MON_STRAP = 3'b101
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_pin_n,
    input  logic               irq_hv,
    input  logic [STRAP_W-1:0] straps,
    input  logic               swi_exec,
    output mode_e              mode
);

    logic [STRAP_W-1:0] bit_ok;
    logic               strap_match;
    logic               pin_q;
    logic               release_edge;
    mode_e              mode_q;

    generate
        for (genvar i = 0; i < STRAP_W; i++) begin : g_strap_cmp
            assign bit_ok[i] = (straps[i] == MON_STRAP[i]);
        end
    endgenerate

    assign strap_match  = &bit_ok;
    assign release_edge = rst_pin_n && !pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            mode_q <= MODE_USER;
        end else begin
            pin_q <= rst_pin_n;
            if (!rst_pin_n) begin
                mode_q <= MODE_USER;
            end else if (release_edge) begin
                mode_q <= ((strap_match && irq_hv) || swi_exec) ? MODE_MON : MODE_USER;
            end else if (swi_exec) begin
                mode_q <= MODE_MON;
            end
        end
    end

    assign mode = mode_q;

    assert_pin_forces_user_R1: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> (mode_q == MODE_USER));

    assert_mode_held_R3: assert property (@(posedge clk) disable iff (rst)
        (rst_pin_n && pin_q && !swi_exec) |=> $stable(mode_q));

    assert_swi_enters_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_pin_n && swi_exec) |=> (mode_q == MODE_MON));

endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap
    import mon_pkg::*;
#(
    parameter logic [PAGE_W-1:0] USER_VEC_PAGE = 8'hFF,
    parameter logic [PAGE_W-1:0] MON_VEC_PAGE  = 8'hFE,
    parameter logic [PAGE_W-1:0] VEC_WIN_LO    = 8'hFC
) (
    input  mode_e             mode,
    input  logic              vec_fetch,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    bus_addr_t a_in;
    bus_addr_t a_out;
    logic      redirect;

    assign a_in     = bus_addr_t'(addr_in);
    assign redirect = (mode == MODE_MON) && vec_fetch
                      && in_vec_window(a_in, USER_VEC_PAGE, VEC_WIN_LO);

    always_comb begin
        a_out = a_in;
        if (redirect) begin
            a_out.page = MON_VEC_PAGE;
        end
    end

    assign addr_out = a_out;

endmodule

// File: rtl/mon_rom_decode.sv
module mon_rom_decode
    import mon_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_LO = 16'hFE10,
    parameter logic [ADDR_W-1:0] ROM_HI = 16'hFEFF
) (
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel
);

    assign sel = (mode == MODE_MON) && in_span(addr, ROM_LO, ROM_HI);

endmodule

// File: rtl/mon_entry_remap.sv
module mon_entry_remap
    import mon_pkg::*;
#(
    parameter int                 STRAP_W       = 3,
    parameter logic [STRAP_W-1:0] MON_STRAP     = 3'b101,
    parameter logic [7:0]         USER_VEC_PAGE = 8'hFF,
    parameter logic [7:0]         MON_VEC_PAGE  = 8'hFE,
    parameter logic [7:0]         VEC_WIN_LO    = 8'hFC,
    parameter logic [15:0]        ROM_LO        = 16'hFE10,
    parameter logic [15:0]        ROM_HI        = 16'hFEFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_pin_n,
    input  logic               irq_hv,
    input  logic [STRAP_W-1:0] strap_pins,
    input  logic               swi_exec,
    input  logic [15:0]        cpu_addr,
    input  logic               vec_fetch,
    output logic               mon_mode,
    output logic [15:0]        mapped_addr,
    output logic               mon_rom_sel,
    output logic               wdog_disable,
    output logic               clk_sel_xtal
);

    mode_e mode;

    mon_mode_latch #(
        .STRAP_W  (STRAP_W),
        .MON_STRAP(MON_STRAP)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .rst_pin_n(rst_pin_n),
        .irq_hv   (irq_hv),
        .straps   (strap_pins),
        .swi_exec (swi_exec),
        .mode     (mode)
    );

    mon_vec_remap #(
        .USER_VEC_PAGE(USER_VEC_PAGE),
        .MON_VEC_PAGE (MON_VEC_PAGE),
        .VEC_WIN_LO   (VEC_WIN_LO)
    ) u_remap (
        .mode     (mode),
        .vec_fetch(vec_fetch),
        .addr_in  (cpu_addr),
        .addr_out (mapped_addr)
    );

    mon_rom_decode #(
        .ROM_LO(ROM_LO),
        .ROM_HI(ROM_HI)
    ) u_rom (
        .mode(mode),
        .addr(mapped_addr),
        .sel (mon_rom_sel)
    );

    assign mon_mode     = (mode == MODE_MON);
    assign wdog_disable = (mode == MODE_MON);
    assign clk_sel_xtal = (mode == MODE_MON);

    assert_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (!vec_fetch || !mon_mode) |-> (mapped_addr == cpu_addr));

    assert_reset_vec_R5: assert property (@(posedge clk) disable iff (rst)
        (mon_mode && vec_fetch && cpu_addr == {USER_VEC_PAGE, 8'hFE})
        |-> (mapped_addr == {MON_VEC_PAGE, 8'hFE}));

    assert_rom_sel_mode_R8: assert property (@(posedge clk) disable iff (rst)
        mon_rom_sel |-> mon_mode);

endmodule

// File: tb/mon_entry_remap_tb.sv
module mon_entry_remap_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin_n = 1'b0;
    logic        irq_hv = 1'b0;
    logic [2:0]  strap_pins = 3'b000;
    logic        swi_exec = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        vec_fetch = 1'b0;
    logic        mon_mode;
    logic [15:0] mapped_addr;
    logic        mon_rom_sel;
    logic        wdog_disable;
    logic        clk_sel_xtal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mon_entry_remap u_dut (
        .clk         (clk),
        .rst         (rst),
        .rst_pin_n   (rst_pin_n),
        .irq_hv      (irq_hv),
        .strap_pins  (strap_pins),
        .swi_exec    (swi_exec),
        .cpu_addr    (cpu_addr),
        .vec_fetch   (vec_fetch),
        .mon_mode    (mon_mode),
        .mapped_addr (mapped_addr),
        .mon_rom_sel (mon_rom_sel),
        .wdog_disable(wdog_disable),
        .clk_sel_xtal(clk_sel_xtal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input logic exp);
        chk({req, " mon_mode"}, {31'd0, mon_mode}, {31'd0, exp});
        chk({req, " wdog_disable R9"}, {31'd0, wdog_disable}, {31'd0, exp});
        chk({req, " clk_sel_xtal R9"}, {31'd0, clk_sel_xtal}, {31'd0, exp});
    endtask

    // Hold the pin low, then release it with the given straps; sample after the update edge.
    task automatic release_pin(input logic [2:0] s, input logic hv);
        @(negedge clk);
        rst_pin_n  = 1'b0;
        strap_pins = s;
        irq_hv     = hv;
        @(negedge clk);
        @(negedge clk);
        chk_mode("R1 pin low", 1'b0);
        rst_pin_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus(input string req, input logic [15:0] a, input logic vf,
                       input logic [15:0] exp_a, input logic exp_sel);
        @(negedge clk);
        cpu_addr  = a;
        vec_fetch = vf;
        #1;
        chk({req, " mapped_addr"}, {16'd0, mapped_addr}, {16'd0, exp_a});
        chk({req, " mon_rom_sel"}, {31'd0, mon_rom_sel}, {31'd0, exp_sel});
    endtask

    task automatic t_power_on;
        @(negedge clk);
        chk_mode("R1 sync reset", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_mode("R1 pin still low", 1'b0);
    endtask

    task automatic t_strap_entry;
        release_pin(3'b101, 1'b1);
        chk_mode("R2 correct straps with hv", 1'b1);
        release_pin(3'b101, 1'b0);
        chk_mode("R2 no hv", 1'b0);
        release_pin(3'b100, 1'b1);
        chk_mode("R2 strap bit0 wrong", 1'b0);
        release_pin(3'b111, 1'b1);
        chk_mode("R2 strap bit1 wrong", 1'b0);
        release_pin(3'b001, 1'b1);
        chk_mode("R2 strap bit2 wrong", 1'b0);
    endtask

    task automatic t_hold;
        release_pin(3'b101, 1'b1);
        @(negedge clk);
        strap_pins = 3'b000;
        irq_hv     = 1'b0;
        repeat (4) @(negedge clk);
        chk_mode("R3 monitor held after straps change", 1'b1);
        release_pin(3'b000, 1'b0);
        @(negedge clk);
        strap_pins = 3'b101;
        irq_hv     = 1'b1;
        repeat (4) @(negedge clk);
        chk_mode("R3 user held after straps match", 1'b0);
    endtask

    task automatic t_swi;
        release_pin(3'b000, 1'b0);
        chk_mode("R4 before swi", 1'b0);
        @(negedge clk);
        swi_exec = 1'b1;
        @(negedge clk);
        swi_exec = 1'b0;
        chk_mode("R4 after swi", 1'b1);
        repeat (3) @(negedge clk);
        chk_mode("R4 stays after swi", 1'b1);
        @(negedge clk);
        rst_pin_n = 1'b0;
        @(negedge clk);
        chk_mode("R1 pin low clears swi mode", 1'b0);
    endtask

    task automatic t_vectors;
        release_pin(3'b101, 1'b1);
        bus("R5 reset vec hi", 16'hFFFE, 1'b1, 16'hFEFE, 1'b1);
        bus("R5 reset vec lo", 16'hFFFF, 1'b1, 16'hFEFF, 1'b1);
        bus("R6 swi vec hi",   16'hFFFC, 1'b1, 16'hFEFC, 1'b1);
        bus("R6 swi vec lo",   16'hFFFD, 1'b1, 16'hFEFD, 1'b1);
        bus("R7 data read FFFE", 16'hFFFE, 1'b0, 16'hFFFE, 1'b0);
        bus("R7 other vector FFFA", 16'hFFFA, 1'b1, 16'hFFFA, 1'b0);
        bus("R8 rom low edge", 16'hFE10, 1'b0, 16'hFE10, 1'b1);
        bus("R8 below rom", 16'hFE0F, 1'b0, 16'hFE0F, 1'b0);
        bus("R8 above rom", 16'hFF00, 1'b0, 16'hFF00, 1'b0);
        release_pin(3'b000, 1'b0);
        bus("R7 user vec fetch", 16'hFFFE, 1'b1, 16'hFFFE, 1'b0);
        bus("R8 user mode rom range", 16'hFE80, 1'b0, 16'hFE80, 1'b0);
        @(negedge clk);
        vec_fetch = 1'b0;
    endtask

    initial begin
        t_power_on();
        t_strap_entry();
        t_hold();
        t_swi();
        t_vectors();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule